// File: doc/BRIEF.md
# Inclusive L2 alias detector

This block is the control path of a second-level cache that is indexed and tagged by physical line address. It is direct-mapped and inclusive of a first-level cache that is indexed by virtual address. The first-level index has a few bits above the page offset, and two virtual names of one physical page can disagree in those bits. Without a guard, one physical line could then sit in two first-level sets at once, and a write through one copy would not be seen through the other. To prevent this, every second-level line records the upper virtual index bits that the first-level copy was filled under.

Each first-level miss arrives as a physical line address together with its upper virtual index bits. If the line is present and the recorded bits match, the line is returned at once. If the line is present under other bits, the controller first purges the older first-level copy. It does this with a one-cycle invalidate pulse that carries the old virtual bits, waits for the acknowledge, rewrites the recorded bits and only then returns the line.

On a miss, a valid line in the target set is evicted first, again with an acknowledged invalidate to the first level, so that inclusion holds. The line is then fetched from main memory over a request/acknowledge handshake. The first level is write-through, so a purge or an eviction never carries dirty data back.

Top module: `alias_guard_l2`

## Requirements
- R1: After reset `req_ready` is 1, `inv_valid`, `mem_req_valid` and `fill_valid` are 0, and every line is invalid, so the first request to any set goes to memory with no invalidate.
- R2: A request whose set holds no valid line raises `mem_req_valid` with `mem_req_pa` equal to the request address in the second cycle after acceptance, with no invalidate. The fill carries the word from `mem_rdata`.
- R3: A request that hits with equal recorded virtual bits returns `fill_valid` in the second cycle after acceptance, with the stored word. It raises no invalidate and no memory request.
- R4: A request that hits with different recorded virtual bits raises `inv_valid` for exactly one cycle, in the second cycle after acceptance. `inv_pa` is the request address and `inv_vx` is the previously recorded bits. No memory request follows.
- R5: After a purge, `fill_valid` is held off until `inv_ack` has been seen and appears in the cycle after the one in which `inv_ack` is high. `fill_vx` and `fill_pa` are the new request's values.
- R6: After a purge the line records the new bits: a repeat under the new bits hits without a purge, and a request under the old bits purges with `inv_vx` equal to the new bits.
- R7: A miss whose set holds a valid line of another tag first raises a one-cycle `inv_valid`. `inv_pa` is formed from the victim's tag as the high bits and the set index as the low `SET_W` bits, and `inv_vx` is the victim's recorded bits. `mem_req_valid` is raised only in the cycle after `inv_ack`.
- R8: `mem_req_valid` and `mem_req_pa` stay unchanged until `mem_ack`. `fill_valid` follows in the next cycle, and the fetched line is installed with the request's virtual bits, so a later equal request hits.
- R9: `req_ready` is 0 from the cycle after acceptance through the fill cycle, and 1 again in the cycle after the fill.
- R10: At most one of `inv_valid`, `mem_req_valid` and `fill_valid` is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | First-level miss request |
| req_ready | output | 1 | Controller idle, request accepted when both high |
| req_pa | input | PA_W | Physical line address of the miss |
| req_vx | input | VX_W | Upper virtual index bits of the miss |
| inv_valid | output | 1 | One-cycle invalidate to the first level |
| inv_pa | output | PA_W | Physical line address of the copy to drop |
| inv_vx | output | VX_W | Upper virtual index bits of the copy to drop |
| inv_ack | input | 1 | Invalidate completed |
| mem_req_valid | output | 1 | Line fetch request, held until acknowledged |
| mem_req_pa | output | PA_W | Physical line address to fetch |
| mem_ack | input | 1 | Fetch done, data on mem_rdata |
| mem_rdata | input | DATA_W | Fetched line word |
| fill_valid | output | 1 | One-cycle fill response to the first level |
| fill_pa | output | PA_W | Physical line address of the fill |
| fill_vx | output | VX_W | Virtual bits the fill is placed under |
| fill_data | output | DATA_W | Line word |

## Verification
Acceptance happens on a clock edge, and the first decision, which is a fill, an invalidate or a memory request, is due in the second cycle after that edge. Any later event is due in the cycle after the acknowledge that releases it. The bench drives requests and acknowledges at the falling edge and samples every output at the next falling edge. It numbers each sample from the accepting edge and compares the sample number of every event with the number its own model of the line store predicts. Acknowledge delays are drawn at random, so the "cycle after the acknowledge" rule is checked against varying waits rather than a fixed latency.

// File: rtl/alias_guard_pkg.sv
package alias_guard_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOOK, ST_INV, ST_WAIT, ST_MEM, ST_FILL
  } ctl_state_e;

  typedef enum logic [1:0] {
    LK_MISS_CLEAN, LK_MISS_VICTIM, LK_HIT_SAME, LK_HIT_ALIAS
  } lookup_e;

endpackage

// File: rtl/alias_guard_store.sv
module alias_guard_store #(
  parameter int SETS   = 16,
  parameter int TAG_W  = 8,
  parameter int VX_W   = 2,
  parameter int DATA_W = 32,
  localparam int SET_W = $clog2(SETS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SET_W-1:0]  rd_set,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [VX_W-1:0]   rd_vx,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_line_en,
  input  logic              wr_vx_en,
  input  logic [SET_W-1:0]  wr_set,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [VX_W-1:0]   wr_vx,
  input  logic [DATA_W-1:0] wr_data
);

  logic              vld_a  [SETS];
  logic [TAG_W-1:0]  tag_a  [SETS];
  logic [VX_W-1:0]   vx_a   [SETS];
  logic [DATA_W-1:0] data_a [SETS];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic              v_q;
    logic [TAG_W-1:0]  t_q;
    logic [VX_W-1:0]   x_q;
    logic [DATA_W-1:0] d_q;
    logic              sel;

    assign sel = (wr_set == SET_W'(s));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        t_q <= '0;
        x_q <= '0;
        d_q <= '0;
      end else if (sel && wr_line_en) begin
        v_q <= 1'b1;
        t_q <= wr_tag;
        x_q <= wr_vx;
        d_q <= wr_data;
      end else if (sel && wr_vx_en) begin
        x_q <= wr_vx;
      end
    end

    assign vld_a[s]  = v_q;
    assign tag_a[s]  = t_q;
    assign vx_a[s]   = x_q;
    assign data_a[s] = d_q;
  end

  assign rd_valid = vld_a[rd_set];
  assign rd_tag   = tag_a[rd_set];
  assign rd_vx    = vx_a[rd_set];
  assign rd_data  = data_a[rd_set];

endmodule

// File: rtl/alias_guard_lookup.sv
module alias_guard_lookup
  import alias_guard_pkg::*;
#(
  parameter int TAG_W = 8,
  parameter int VX_W  = 2
) (
  input  logic             line_valid,
  input  logic [TAG_W-1:0] line_tag,
  input  logic [VX_W-1:0]  line_vx,
  input  logic [TAG_W-1:0] want_tag,
  input  logic [VX_W-1:0]  want_vx,
  output logic             tag_hit,
  output logic             vx_differs,
  output lookup_e          kind
);

  assign tag_hit    = line_valid && (line_tag == want_tag);
  assign vx_differs = (line_vx != want_vx);

  always_comb begin
    if (tag_hit)         kind = vx_differs ? LK_HIT_ALIAS : LK_HIT_SAME;
    else if (line_valid) kind = LK_MISS_VICTIM;
    else                 kind = LK_MISS_CLEAN;
  end

endmodule

// File: rtl/alias_guard_seq.sv
module alias_guard_seq
  import alias_guard_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_fire,
  input  lookup_e    kind,
  input  logic       inv_ack,
  input  logic       mem_ack,
  output logic       ready,
  output logic       look_en,
  output logic       inv_pulse,
  output logic       mem_en,
  output logic       fill_pulse,
  output logic       upd_vx,
  output logic       install
);

  ctl_state_e state_q, state_d;
  logic       purge_q, purge_d;

  always_comb begin
    state_d = state_q;
    purge_d = purge_q;
    unique case (state_q)
      ST_IDLE: if (req_fire) state_d = ST_LOOK;
      ST_LOOK: begin
        unique case (kind)
          LK_HIT_SAME:    state_d = ST_FILL;
          LK_HIT_ALIAS:   begin state_d = ST_INV; purge_d = 1'b1; end
          LK_MISS_VICTIM: begin state_d = ST_INV; purge_d = 1'b0; end
          default:        state_d = ST_MEM;
        endcase
      end
      ST_INV:  state_d = ST_WAIT;
      ST_WAIT: if (inv_ack) state_d = purge_q ? ST_FILL : ST_MEM;
      ST_MEM:  if (mem_ack) state_d = ST_FILL;
      ST_FILL: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      purge_q <= 1'b0;
    end else begin
      state_q <= state_d;
      purge_q <= purge_d;
    end
  end

  logic waiting;
  assign waiting    = (state_q == ST_WAIT);
  assign ready      = (state_q == ST_IDLE);
  assign look_en    = (state_q == ST_LOOK);
  assign inv_pulse  = (state_q == ST_INV);
  assign mem_en     = (state_q == ST_MEM);
  assign fill_pulse = (state_q == ST_FILL);
  assign upd_vx     = waiting && inv_ack && purge_q;
  assign install    = mem_en && mem_ack;

  assert_inv_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    inv_pulse |=> !inv_pulse);
  assert_hold_until_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && !inv_ack) |=> (!fill_pulse && !mem_en));
  assert_outputs_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({inv_pulse, mem_en, fill_pulse}));
  assert_ready_returns_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fill_pulse |=> ready);
  assert_victim_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (look_en && kind == LK_MISS_VICTIM) |=> (inv_pulse && !mem_en));

endmodule

// File: rtl/alias_guard_l2.sv
module alias_guard_l2
  import alias_guard_pkg::*;
#(
  parameter int PA_W   = 12,
  parameter int SETS   = 16,
  parameter int VX_W   = 2,
  parameter int DATA_W = 32,
  localparam int SET_W = $clog2(SETS),
  localparam int TAG_W = PA_W - SET_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [PA_W-1:0]   req_pa,
  input  logic [VX_W-1:0]   req_vx,
  output logic              inv_valid,
  output logic [PA_W-1:0]   inv_pa,
  output logic [VX_W-1:0]   inv_vx,
  input  logic              inv_ack,
  output logic              mem_req_valid,
  output logic [PA_W-1:0]   mem_req_pa,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              fill_valid,
  output logic [PA_W-1:0]   fill_pa,
  output logic [VX_W-1:0]   fill_vx,
  output logic [DATA_W-1:0] fill_data
);

  function automatic logic [SET_W-1:0] line_set(input logic [PA_W-1:0] pa);
    return pa[SET_W-1:0];
  endfunction

  function automatic logic [TAG_W-1:0] line_tag(input logic [PA_W-1:0] pa);
    return pa[PA_W-1:SET_W];
  endfunction

  function automatic logic [PA_W-1:0] line_join(input logic [TAG_W-1:0] t,
                                                input logic [SET_W-1:0] s);
    return {t, s};
  endfunction

  logic              req_fire;
  logic [PA_W-1:0]   pa_q;
  logic [VX_W-1:0]   vx_q;

  logic              rd_valid;
  logic [TAG_W-1:0]  rd_tag;
  logic [VX_W-1:0]   rd_vx;
  logic [DATA_W-1:0] rd_data;

  logic              tag_hit, vx_differs;
  lookup_e           kind;
  logic              look_en, inv_pulse, mem_en, fill_pulse, upd_vx, install;

  assign req_fire = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa_q <= '0;
      vx_q <= '0;
    end else if (req_fire) begin
      pa_q <= req_pa;
      vx_q <= req_vx;
    end
  end

  alias_guard_store #(
    .SETS(SETS), .TAG_W(TAG_W), .VX_W(VX_W), .DATA_W(DATA_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .rd_set(line_set(pa_q)),
    .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_vx(rd_vx), .rd_data(rd_data),
    .wr_line_en(install), .wr_vx_en(upd_vx),
    .wr_set(line_set(pa_q)), .wr_tag(line_tag(pa_q)),
    .wr_vx(vx_q), .wr_data(mem_rdata)
  );

  alias_guard_lookup #(.TAG_W(TAG_W), .VX_W(VX_W)) u_lookup (
    .line_valid(rd_valid), .line_tag(rd_tag), .line_vx(rd_vx),
    .want_tag(line_tag(pa_q)), .want_vx(vx_q),
    .tag_hit(tag_hit), .vx_differs(vx_differs), .kind(kind)
  );

  alias_guard_seq u_seq (
    .clk(clk), .rst_n(rst_n), .req_fire(req_fire), .kind(kind),
    .inv_ack(inv_ack), .mem_ack(mem_ack),
    .ready(req_ready), .look_en(look_en), .inv_pulse(inv_pulse),
    .mem_en(mem_en), .fill_pulse(fill_pulse), .upd_vx(upd_vx),
    .install(install)
  );

  assign inv_valid     = inv_pulse;
  assign inv_pa        = line_join(rd_tag, line_set(pa_q));
  assign inv_vx        = rd_vx;
  assign mem_req_valid = mem_en;
  assign mem_req_pa    = pa_q;
  assign fill_valid    = fill_pulse;
  assign fill_pa       = pa_q;
  assign fill_vx       = vx_q;
  assign fill_data     = rd_data;

  assert_alias_purge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (look_en && tag_hit && vx_differs) |=>
      (inv_valid && inv_vx == $past(rd_vx) && inv_pa == $past(pa_q)));
  assert_hit_direct_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (look_en && tag_hit && !vx_differs) |=> (fill_valid && fill_data == $past(rd_data)));
  assert_mem_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_ack) |=> (mem_req_valid && $stable(mem_req_pa)));
  assert_installed_vx_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |-> (rd_valid && rd_vx == fill_vx && rd_tag == line_tag(fill_pa)));

endmodule

// File: tb/tb_alias_guard_l2.sv
module tb_alias_guard_l2;
  localparam int CLK_PERIOD = 10;
  localparam int PA_W = 12, SETS = 16, VX_W = 2, DATA_W = 32;
  localparam int SET_W = 4;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, inv_ack = 0, mem_ack = 0;
  logic [PA_W-1:0] req_pa = '0;
  logic [VX_W-1:0] req_vx = '0;
  logic [DATA_W-1:0] mem_rdata = '0;
  logic req_ready, inv_valid, mem_req_valid, fill_valid;
  logic [PA_W-1:0] inv_pa, mem_req_pa, fill_pa;
  logic [VX_W-1:0] inv_vx, fill_vx;
  logic [DATA_W-1:0] fill_data;

  alias_guard_l2 #(.PA_W(PA_W), .SETS(SETS), .VX_W(VX_W), .DATA_W(DATA_W)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // bench model of the line store
  bit          m_v   [SETS];
  int unsigned m_tag [SETS];
  int unsigned m_vx  [SETS];

  function automatic logic [DATA_W-1:0] mem_word(input logic [PA_W-1:0] pa);
    return ({pa, 20'h0} ^ (32'(pa) * 32'h0001_9E37)) ^ 32'hA5C3_0F1E;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // kind codes: 0 cold miss, 1 victim miss, 2 hit same bits, 3 hit alias
  task automatic run_req(input logic [PA_W-1:0] pa, input logic [VX_W-1:0] vx);
    int s = int'(pa[SET_W-1:0]);
    int unsigned tg = int'(pa[PA_W-1:SET_W]);
    int kind;
    int n = 1, inv_at = -1, inv_cnt = 0, ack_at = -1, inv_due = -1;
    int mem_at = -1, mack_at = -1, mem_due = -1, fill_at = -1, multi = 0;
    logic [PA_W-1:0] ipa = '0, mpa = '0, fpa = '0;
    logic [VX_W-1:0] ivx = '0, fvx = '0;
    logic [DATA_W-1:0] fdat = '0;
    bit mem_moved = 0;
    if (!m_v[s]) kind = 0;
    else if (m_tag[s] != tg) kind = 1;
    else if (m_vx[s] == int'(vx)) kind = 2;
    else kind = 3;

    chk(req_ready == 1'b1, "R9 ready before request", req_ready, 1);
    req_valid = 1; req_pa = pa; req_vx = vx;
    @(negedge clk);
    req_valid = 0;
    chk(req_ready == 1'b0 && !inv_valid && !mem_req_valid && !fill_valid,
        "R9 busy after accept", {req_ready, inv_valid, mem_req_valid, fill_valid}, 0);
    while (fill_at < 0 && n < 60) begin
      @(negedge clk);
      n++;
      inv_ack = 0; mem_ack = 0;
      if (int'(inv_valid) + int'(mem_req_valid) + int'(fill_valid) > 1) multi++;
      if (inv_valid) begin
        inv_cnt++;
        if (inv_at < 0) begin inv_at = n; ipa = inv_pa; ivx = inv_vx; end
        inv_due = n + 1 + int'($urandom_range(0, 3));
      end
      if (mem_req_valid) begin
        if (mem_at < 0) begin mem_at = n; mpa = mem_req_pa; mem_due = n + 1 + int'($urandom_range(0, 4)); end
        else if (mem_req_pa != mpa) mem_moved = 1;
      end
      if (fill_valid) begin fill_at = n; fpa = fill_pa; fvx = fill_vx; fdat = fill_data; end
      if (n == inv_due) begin inv_ack = 1; ack_at = n; end
      if (n == mem_due && mem_req_valid) begin mem_ack = 1; mem_rdata = mem_word(mpa); mack_at = n; end
    end
    @(negedge clk);
    inv_ack = 0; mem_ack = 0;
    chk(req_ready == 1'b1 && !fill_valid, "R9 ready after fill", req_ready, 1);
    chk(multi == 0, "R10 one output at a time", multi, 0);
    chk(fill_at > 0, "R3/R5 fill arrives", fill_at, 1);
    chk(fdat == mem_word(pa), "R8 fill data", fdat, mem_word(pa));
    chk(fvx == vx && fpa == pa, "R5 fill address and bits", {fpa, fvx}, {pa, vx});
    chk(!mem_moved, "R8 memory request held", mem_moved, 0);
    case (kind)
      0: begin
        chk(inv_cnt == 0, "R2 no invalidate on clean miss", inv_cnt, 0);
        chk(mem_at == 2 && mpa == pa, "R2 memory request", mem_at, 2);
        chk(fill_at == mack_at + 1, "R8 fill after memory ack", fill_at, mack_at + 1);
      end
      1: begin
        chk(inv_cnt == 1 && inv_at == 2, "R7 single victim invalidate", inv_at, 2);
        chk(ipa == {PA_W'(m_tag[s] << SET_W)} + PA_W'(s) && ivx == VX_W'(m_vx[s]),
            "R7 victim address and bits", {ipa, ivx}, {PA_W'(m_tag[s] << SET_W) + PA_W'(s), VX_W'(m_vx[s])});
        chk(mem_at == ack_at + 1, "R7 memory after invalidate ack", mem_at, ack_at + 1);
        chk(fill_at == mack_at + 1, "R8 fill after memory ack", fill_at, mack_at + 1);
      end
      2: begin
        chk(fill_at == 2, "R3 direct hit latency", fill_at, 2);
        chk(inv_cnt == 0 && mem_at < 0, "R3 no purge no fetch", inv_cnt, 0);
      end
      default: begin
        chk(inv_cnt == 1 && inv_at == 2, "R4 single purge pulse", inv_at, 2);
        chk(ipa == pa && ivx == VX_W'(m_vx[s]), "R4 purge address and old bits",
            {ipa, ivx}, {pa, VX_W'(m_vx[s])});
        chk(mem_at < 0, "R4 no fetch on alias", mem_at, -1);
        chk(fill_at == ack_at + 1, "R5 fill after invalidate ack", fill_at, ack_at + 1);
      end
    endcase
    m_v[s] = 1; m_tag[s] = tg; m_vx[s] = int'(vx);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", n_chk, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    for (int i = 0; i < SETS; i++) begin m_v[i] = 0; m_tag[i] = 0; m_vx[i] = 0; end
    repeat (3) @(negedge clk);
    chk(req_ready && !inv_valid && !mem_req_valid && !fill_valid, "R1 reset outputs",
        {req_ready, inv_valid, mem_req_valid, fill_valid}, 4'b1000);
    rst_n = 1;
    @(negedge clk);
    run_req(12'h012, 2'd1);  // R1/R2 cold
    run_req(12'h012, 2'd1);  // R3 hit
    run_req(12'h012, 2'd2);  // R4/R5 alias
    run_req(12'h012, 2'd2);  // R6 new bits hit
    run_req(12'h012, 2'd1);  // R6 purge carries new bits
    run_req(12'h112, 2'd0);  // R7 victim
    run_req(12'h012, 2'd3);  // R7/R8 evict back
    run_req(12'h012, 2'd3);  // R8 installed line hits
    for (int k = 0; k < 300; k++) begin
      logic [PA_W-1:0] pa;
      pa = {PA_W'($urandom_range(0, 2)) << SET_W} | PA_W'($urandom_range(0, SETS - 1));
      run_req(pa, VX_W'($urandom_range(0, 3)));
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule